// File: doc/BRIEF.md
# Fixed-Event Power Status Logic

This block keeps the status and enable registers for five fixed power-management events. The events are a qualified power-button press, a firmware global-lock release, bus-master activity, a real-time-clock alarm and a timer carry. Each event sets a sticky status bit. Software clears a status bit by writing a one to it. A matching enable bit routes a set status bit onto a shared interrupt request line.

The power-button input is raw. It is synchronized and then timed against a millisecond tick. A short press is ignored. A press held past the qualification window sets the button status. A press held past the long window clears that status and emits a one-cycle forced soft-off request.

While the platform sleeps, the block raises a wake request. A set button status does this even when its enable bit is clear. Any enabled status bit does the same.

The registers sit in the always-powered domain. Only the reset input of this block clears them.

Top module: `pm1_evt_block`

## Requirements
- R1: After reset, both registers read 0 and `irq_o`, `wake_o` and `soft_off_o` are low.
- R2: Button status (status bit 8) sets only after the synchronized button input has stayed high for more than QUAL_MS consecutive ticks. Any low level restarts the count.
- R3: When the button stays high for more than LONG_MS ticks, button status clears. At the same time `soft_off_o` pulses high for exactly one cycle, once per press.
- R4: The status register is at address 0. Its bits are RTC 10, button 8, global 5, bus master 4 and timer 0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: A set event in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R6: The enable register is at address 2, with writable bits 10, 8, 5 and 0. Every other bit of either register, and every other address, reads 0.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both set.
- R8: `wake_o` is high while `sleeping_i` is high and either button status is set or any enabled status bit is set.
- R9: Global status sets on a lock-release pulse only when the pending input is high.
- R10: Bus-master status sets on the cycle after a bus request. It has no enable and never drives `irq_o`.
- R11: Timer status sets when the timer MSB input changes in either direction, once per change.
- R12: RTC status sets on an RTC event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high standby-domain reset |
| btn_raw_i | input | 1 | Raw power-button level, high = pressed |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| lock_release_i | input | 1 | Firmware released the global lock (pulse) |
| lock_pending_i | input | 1 | Global lock pending indication |
| bm_req_i | input | 1 | A bus master requested the bus |
| rtc_evt_i | input | 1 | RTC alarm pulse |
| tmr_msb_i | input | 1 | Most significant bit of the free-running timer |
| sleeping_i | input | 1 | Platform is in a sleep or soft-off state |
| reg_addr_i | input | 2 | Register address (0 status, 2 enable) |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |
| soft_off_o | output | 1 | One-cycle forced soft-off request |

## Verification
The bench sweeps press lengths from zero ticks to past the long window on a small configuration. A qualifier off by one tick would set status one step early or late. A counter that fails to saturate would emit repeated soft-off pulses. A short press interrupted by a release is also tried: a count that does not restart would qualify a press that is too short.

All sixteen enable combinations are swept with every status bit set. This catches a wrong bit position or a bus-master bit leaking into the interrupt.

Same-cycle set and clear, timer changes in both directions, and wake with the button enable cleared are also probed. These catch a clear that wins over a set, a timer detector that sees only one edge, and a wake path that wrongly honours the enable bit.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    // Bit positions shared with software.
    localparam int B_TMR = 0;
    localparam int B_BM  = 4;
    localparam int B_GBL = 5;
    localparam int B_PB  = 8;
    localparam int B_RTC = 10;

    localparam logic [ADDR_W-1:0] ADDR_STS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_EN  = 2'd2;

    typedef struct packed {
        logic rtc;
        logic pb;
        logic gbl;
        logic bm;
        logic tmr;
    } evt_t;

    function automatic logic [REG_W-1:0] evt_to_vec(input evt_t e);
        logic [REG_W-1:0] v;
        v        = '0;
        v[B_TMR] = e.tmr;
        v[B_BM]  = e.bm;
        v[B_GBL] = e.gbl;
        v[B_PB]  = e.pb;
        v[B_RTC] = e.rtc;
        return v;
    endfunction

    localparam evt_t ALL_EVT   = '{rtc: 1'b1, pb: 1'b1, gbl: 1'b1, bm: 1'b1, tmr: 1'b1};
    localparam evt_t EN_EVT    = '{rtc: 1'b1, pb: 1'b1, gbl: 1'b1, bm: 1'b0, tmr: 1'b1};
    localparam logic [REG_W-1:0] STS_MASK = evt_to_vec(ALL_EVT);
    localparam logic [REG_W-1:0] EN_MASK  = evt_to_vec(EN_EVT);

endpackage

// File: rtl/pm1_btn_qual.sv
module pm1_btn_qual #(
    parameter int QUAL_MS = 16,
    parameter int LONG_MS = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw_i,
    input  logic tick_i,
    output logic held_o,
    output logic qual_o,
    output logic long_o,
    output logic long_q_o
);
    localparam int CNT_W = $clog2(LONG_MS + 2);
    localparam logic [CNT_W-1:0] QUAL_C = CNT_W'(QUAL_MS);
    localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG_MS);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(LONG_MS + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    assign held_o = sync_q[1];
    assign adv    = sync_q[1] && tick_i;
    assign qual_o = adv && (cnt_q == QUAL_C);
    assign long_o = adv && (cnt_q == LONG_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            cnt_q    <= '0;
            long_q_o <= 1'b0;
        end else begin
            sync_q   <= {sync_q[0], btn_raw_i};
            long_q_o <= long_o;
            if (!sync_q[1]) begin
                cnt_q <= '0;
            end else if (tick_i && cnt_q != SAT_C) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pm1_sts_bank.sv
module pm1_sts_bank
    import pm1_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK = STS_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] sts_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    sts_o[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    sts_o[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    sts_o[i] <= 1'b0;
                end
            end
        end else begin : g_rsvd
            assign sts_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pm1_evt_route.sv
module pm1_evt_route
    import pm1_pkg::*;
(
    input  logic [REG_W-1:0] sts_i,
    input  logic [REG_W-1:0] en_i,
    input  logic             sleeping_i,
    output logic             irq_o,
    output logic             wake_o
);
    logic any_en;
    assign any_en = |(sts_i & en_i & EN_MASK);
    assign irq_o  = any_en;
    assign wake_o = sleeping_i && (any_en || sts_i[B_PB]);
endmodule

// File: rtl/pm1_evt_block.sv
module pm1_evt_block
    import pm1_pkg::*;
#(
    parameter int QUAL_MS = 16,
    parameter int LONG_MS = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_raw_i,
    input  logic              ms_tick_i,
    input  logic              lock_release_i,
    input  logic              lock_pending_i,
    input  logic              bm_req_i,
    input  logic              rtc_evt_i,
    input  logic              tmr_msb_i,
    input  logic              sleeping_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              soft_off_o
);
    logic             btn_held, pb_qual, pb_long;
    logic             tmr_prev_q;
    logic [REG_W-1:0] en_q, sts_q;
    logic [REG_W-1:0] set_vec, clr_vec;
    evt_t             set_e;

    pm1_btn_qual #(.QUAL_MS(QUAL_MS), .LONG_MS(LONG_MS)) u_btn (
        .clk      (clk),
        .rst      (rst),
        .btn_raw_i(btn_raw_i),
        .tick_i   (ms_tick_i),
        .held_o   (btn_held),
        .qual_o   (pb_qual),
        .long_o   (pb_long),
        .long_q_o (soft_off_o)
    );

    always_comb begin
        set_e.pb  = pb_qual;
        set_e.gbl = lock_release_i && lock_pending_i;
        set_e.bm  = bm_req_i;
        set_e.rtc = rtc_evt_i;
        set_e.tmr = tmr_msb_i ^ tmr_prev_q;
        set_vec   = evt_to_vec(set_e);
        clr_vec   = (reg_wr_i && reg_addr_i == ADDR_STS) ? reg_wdata_i : '0;
        clr_vec[B_PB] = clr_vec[B_PB] | pb_long;
    end

    pm1_sts_bank #(.MASK(STS_MASK)) u_sts (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .sts_o  (sts_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            tmr_prev_q <= 1'b0;
        end else begin
            tmr_prev_q <= tmr_msb_i;
            if (reg_wr_i && reg_addr_i == ADDR_EN) begin
                en_q <= reg_wdata_i & EN_MASK;
            end
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_STS: reg_rdata_o = sts_q;
            ADDR_EN:  reg_rdata_o = en_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    pm1_evt_route u_route (
        .sts_i     (sts_q),
        .en_i      (en_q),
        .sleeping_i(sleeping_i),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );
endmodule

// File: rtl/pm1_evt_chk.sv
module pm1_evt_chk
    import pm1_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bm_req_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              sleeping_i,
    input logic              wake_o,
    input logic              soft_off_o,
    input logic [REG_W-1:0]  sts_q,
    input logic              btn_held
);
    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == ADDR_STS) |-> ((reg_rdata_o & ~STS_MASK) == '0));

    // R3
    long_clears_chk: assert property (@(posedge clk) disable iff (rst)
        soft_off_o |-> !sts_q[B_PB]);

    // R3
    soft_off_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        soft_off_o |=> !soft_off_o);

    // R2
    pb_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[B_PB]) |-> $past(btn_held));

    // R4
    w1c_bm_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == ADDR_STS && reg_wdata_i[B_BM] && !bm_req_i)
        |=> !sts_q[B_BM]);

    // R10
    bm_set_chk: assert property (@(posedge clk) disable iff (rst)
        bm_req_i |=> sts_q[B_BM]);

    // R8
    pb_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping_i && sts_q[B_PB]) |-> wake_o);
endmodule

bind pm1_evt_block pm1_evt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bm_req_i   (bm_req_i),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .sleeping_i (sleeping_i),
    .wake_o     (wake_o),
    .soft_off_o (soft_off_o),
    .sts_q      (sts_q),
    .btn_held   (btn_held)
);

// File: tb/pm1_evt_block_tb.sv
`timescale 1ns/1ps
module pm1_evt_block_tb;
    localparam int QUAL = 3;
    localparam int LONG = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 0, tick = 0, rel = 0, pend = 0, bm = 0, rtc = 0, tmr = 0, slp = 0;
    logic [1:0]  addr = 0;
    logic        wr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        irq, wake, soff;

    int checks = 0;
    int fails  = 0;
    int so_cnt = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pm1_evt_block #(.QUAL_MS(QUAL), .LONG_MS(LONG)) u_dut (
        .clk(clk), .rst(rst), .btn_raw_i(btn), .ms_tick_i(tick),
        .lock_release_i(rel), .lock_pending_i(pend), .bm_req_i(bm),
        .rtc_evt_i(rtc), .tmr_msb_i(tmr), .sleeping_i(slp),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake), .soft_off_o(soff)
    );

    always @(negedge clk) if (!rst && soff) so_cnt++;

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic wrr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1; cyc(); wr = 0;
    endtask

    task automatic tk();
        tick = 1; cyc(); tick = 0; cyc();
    endtask

    task automatic press(input int n);
        btn = 1; cyc(3);
        repeat (n) tk();
    endtask

    task automatic unpress();
        btn = 0; cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int base;
        cyc(4); rst = 0; cyc();

        // R1 reset state
        rd(0, d); chk("R1 status", d, 0);
        rd(2, d); chk("R1 enable", d, 0);
        chk("R1 outputs", {irq, wake, soff}, 0);

        // R6 enable layout and unused addresses
        wrr(2, 16'hFFFF);
        rd(2, d); chk("R6 enable mask", d, 16'h0521);
        rd(1, d); chk("R6 addr1", d, 0);
        rd(3, d); chk("R6 addr3", d, 0);
        wrr(2, 0);

        // R2 R3 press-length sweep
        for (int n = 0; n <= LONG + 2; n++) begin
            wrr(0, 16'hFFFF);
            base = so_cnt;
            press(n);
            rd(0, d);
            chk($sformatf("R2 press %0d", n), d[8], (n > QUAL && n <= LONG));
            chk($sformatf("R3 softoff %0d", n), so_cnt - base, (n > LONG) ? 1 : 0);
            unpress();
        end

        // R2 release restarts count
        wrr(0, 16'hFFFF);
        press(QUAL); unpress(); press(QUAL);
        rd(0, d); chk("R2 restart", d[8], 0);
        tk();
        rd(0, d); chk("R2 after restart", d[8], 1);
        unpress();

        // R8 wake with enable clear while sleeping
        slp = 1; #0.5;
        chk("R8 wake disabled pb", {wake, irq}, 2'b10);
        slp = 0; #0.5;
        chk("R8 awake no wake", wake, 0);
        wrr(2, 16'h0100);
        chk("R7 pb irq", irq, 1);
        wrr(0, 16'h0100);
        chk("R4 pb w1c", irq, 0);
        wrr(2, 0);

        // R12 RTC and R8 enabled wake
        rtc = 1; cyc(); rtc = 0;
        rd(0, d); chk("R12 rtc set", d, 16'h0400);
        slp = 1; #0.5; chk("R8 rtc no enable", wake, 0);
        wrr(2, 16'h0400); chk("R8 rtc enabled wake", wake, 1);
        slp = 0; wrr(2, 0); wrr(0, 16'h0400);

        // R9 global
        rel = 1; pend = 0; cyc(); rel = 0;
        rd(0, d); chk("R9 no pending", d, 0);
        pend = 1; cyc(); rd(0, d); chk("R9 pending only", d, 0);
        rel = 1; cyc(); rel = 0; pend = 0;
        rd(0, d); chk("R9 set", d, 16'h0020);
        wrr(0, 16'hFFDF); rd(0, d); chk("R4 write others", d, 16'h0020);
        wrr(0, 16'h0000); rd(0, d); chk("R4 write zero", d, 16'h0020);
        wrr(0, 16'h0020); rd(0, d); chk("R4 clear global", d, 0);

        // R11 timer both directions
        tmr = 1; cyc(); rd(0, d); chk("R11 rise", d, 16'h0001);
        wrr(0, 16'h0001); cyc(2); rd(0, d); chk("R11 steady", d, 0);
        tmr = 0; cyc(); rd(0, d); chk("R11 fall", d, 16'h0001);
        wrr(0, 16'h0001);

        // R10 bus master and R5 set priority
        bm = 1; cyc(); bm = 0;
        rd(0, d); chk("R10 bm set", d, 16'h0010);
        wrr(2, 16'hFFFF); chk("R10 no irq", irq, 0);
        addr = 0; wdata = 16'h0010; wr = 1; bm = 1; cyc(); wr = 0; bm = 0;
        rd(0, d); chk("R5 set wins", d[4], 1);
        wrr(0, 16'h0010); rd(0, d); chk("R4 bm clear", d[4], 0);
        wrr(2, 0);

        // R7 enable sweep with every status set
        rtc = 1; bm = 1; rel = 1; pend = 1; tmr = 1; cyc();
        rtc = 0; bm = 0; rel = 0; pend = 0;
        press(QUAL + 1); unpress();
        rd(0, d); chk("R4 all set", d, 16'h0531);
        for (int e = 0; e < 16; e++) begin
            logic [15:0] ev;
            ev = {5'd0, e[3], 1'b0, e[2], 2'b00, e[1], 4'd0, e[0]};
            wrr(2, ev);
            rd(2, d); chk($sformatf("R6 en %0d", e), d, ev);
            chk($sformatf("R7 irq en %0d", e), irq, (e != 0));
        end
        wrr(0, 16'h0521);
        rd(0, d); chk("R10 bm left", d, 16'h0010);
        chk("R7 irq bm only", irq, 0);

        // R1 reset clears
        rst = 1; cyc(2); rst = 0;
        rd(0, d); chk("R1 status after reset", d, 0);
        rd(2, d); chk("R1 enable after reset", d, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule